// File: doc/BRIEF.md
# Power-Down and Reset-Cause Controller

This block keeps track of whether a small microcontroller core is running or stopped in its low-power halt state, decides what ends that state, and keeps two status flags that let software work out afterwards why the core restarted. A halt command stops the main system oscillator and parks the core. The controller itself runs on a clock that stays alive during halt, such as a dedicated watchdog oscillator.

Four events end halt. An external reset re-initializes the whole device. A watchdog overflow restarts only the program counter and stack pointer. A pending enabled interrupt, or a high-to-low transition on any of the eight port pins, resumes execution with no reset at all. A watchdog overflow while the core is running asks for a full chip reset instead. The power-down flag shows that a halt took place. The time-out flag shows that the watchdog expired.

Top module: `pdc_ctrl`

## Requirements
- R1: After power-on reset, `halted_o`=0, `sys_osc_en_o`=1, `pd_flag_o`=0, `to_flag_o`=0, and both reset requests are 0.
- R2: A halt command while running sets `halted_o`=1, `sys_osc_en_o`=0, `pd_flag_o`=1 and `to_flag_o`=0 on the next clock edge.
- R3: A clear-watchdog command while running clears `pd_flag_o` on the next edge and leaves `to_flag_o` unchanged.
- R4: A watchdog overflow while running sets `to_flag_o` and raises `full_rst_o` for the following cycle, with `halted_o` staying 0.
- R5: A watchdog overflow while halted sets `to_flag_o`, clears `halted_o`, keeps `pd_flag_o`=1 and raises `warm_rst_o` (never `full_rst_o`) for one cycle.
- R6: External reset has the highest priority. In every cycle after one in which it is high, `full_rst_o`=1, both flags are 0 and `halted_o`=0.
- R7: A pending interrupt while halted clears `halted_o` on the next edge, with no reset request and both flags unchanged.
- R8: Port pins pass through a two-flop synchronizer. A 1-to-0 change on any bit while halted clears `halted_o` on the third clock edge after the pin changes. Rising changes, and changes that completed before halt, do not wake.
- R9: While halted, halt and clear-watchdog commands have no effect. `pd_flag_o` stays 1 until an external reset.
- R10: `full_rst_o` and `warm_rst_o` are never high together, and `warm_rst_o` never stays high for two cycles.
- R11: A halt command and a clear-watchdog command in the same running cycle act as a halt: `pd_flag_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_i | input | 1 | External reset request, synchronous, active high |
| halt_cmd_i | input | 1 | Halt command strobe |
| wdt_clr_i | input | 1 | Clear-watchdog command strobe |
| irq_pend_i | input | 1 | Pending enabled interrupt |
| porta_i | input | 8 | Asynchronous port pins |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| sys_osc_en_o | output | 1 | System oscillator enable |
| halted_o | output | 1 | Core is halted |
| pd_flag_o | output | 1 | Power-down flag |
| to_flag_o | output | 1 | Watchdog time-out flag |
| full_rst_o | output | 1 | Full chip reset request |
| warm_rst_o | output | 1 | Warm reset request (program counter and stack pointer) |

## Verification
The assertions assume that every synchronous input is low while power-on reset is in effect. They also assume that halt and clear-watchdog strobes come only from a running core, so a halt entry can always be traced to a halt command one cycle earlier. The bench holds all command inputs at zero and the port pins high through reset. After that it applies random strobes at low rates, so that halts are long enough for interrupts, port edges and overflows to end them. It adds directed runs for rising and falling port changes, for commands issued during halt, and for simultaneous events.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned PDC_PORT_W    = 8;
  localparam int unsigned PDC_SYNC_LEN  = 2;
  localparam int unsigned PDC_RST_LEN   = 2;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_HALT = 1'b1
  } pdc_mode_e;

  typedef struct packed {
    logic pd;
    logic to;
  } pdc_flags_t;

  typedef struct packed {
    logic full;
    logic warm;
  } pdc_rstreq_t;
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdc_port_edge.sv
module pdc_port_edge #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             arm_i,
  output logic             fall_o
);
  logic [WIDTH-1:0] sync_q [STAGES];
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] fall_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '1;
    else        sync_q[0] <= pins_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '1;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '1;
    else        last_q <= sync_q[STAGES-1];
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign fall_bits[b] = last_q[b] & ~sync_q[STAGES-1][b];
  end

  assign fall_o = arm_i & (|fall_bits);
endmodule

// File: rtl/pdc_core.sv
module pdc_core
  import pdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_rst_i,
  input  logic        halt_cmd_i,
  input  logic        wdt_clr_i,
  input  logic        irq_pend_i,
  input  logic        port_fall_i,
  input  logic        wdt_ovf_i,
  output pdc_mode_e   mode_o,
  output pdc_flags_t  flags_o,
  output pdc_rstreq_t req_o
);
  pdc_mode_e   mode_q, mode_d;
  pdc_flags_t  flg_q, flg_d;
  pdc_rstreq_t req_q, req_d;
  logic        wake;

  assign wake = irq_pend_i | port_fall_i;

  always_comb begin
    mode_d = mode_q;
    flg_d  = flg_q;
    req_d  = '0;
    if (ext_rst_i) begin
      mode_d   = MODE_RUN;
      flg_d    = '0;
      req_d.full = 1'b1;
    end else if (wdt_ovf_i) begin
      flg_d.to = 1'b1;
      if (mode_q == MODE_HALT) begin
        mode_d     = MODE_RUN;
        req_d.warm = 1'b1;
      end else begin
        req_d.full = 1'b1;
      end
    end else if (mode_q == MODE_HALT) begin
      if (wake) mode_d = MODE_RUN;
    end else if (halt_cmd_i) begin
      mode_d   = MODE_HALT;
      flg_d.pd = 1'b1;
      flg_d.to = 1'b0;
    end else if (wdt_clr_i) begin
      flg_d.pd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      flg_q  <= '0;
      req_q  <= '0;
    end else begin
      mode_q <= mode_d;
      flg_q  <= flg_d;
      req_q  <= req_d;
    end
  end

  assign mode_o  = mode_q;
  assign flags_o = flg_q;
  assign req_o   = req_q;
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned PORT_W   = PDC_PORT_W,
  parameter int unsigned SYNC_LEN = PDC_SYNC_LEN,
  parameter int unsigned RST_LEN  = PDC_RST_LEN
) (
  input  logic              clk,
  input  logic              por_n_i,
  input  logic              ext_rst_i,
  input  logic              halt_cmd_i,
  input  logic              wdt_clr_i,
  input  logic              irq_pend_i,
  input  logic [PORT_W-1:0] porta_i,
  input  logic              wdt_ovf_i,
  output logic              sys_osc_en_o,
  output logic              halted_o,
  output logic              pd_flag_o,
  output logic              to_flag_o,
  output logic              full_rst_o,
  output logic              warm_rst_o
);
  logic        rst_sync_n;
  logic        port_fall;
  pdc_mode_e   mode;
  pdc_flags_t  flags;
  pdc_rstreq_t req;

  pdc_rst_sync #(.STAGES(RST_LEN)) u_rst (
    .clk      (clk),
    .arst_n_i (por_n_i),
    .rst_n_o  (rst_sync_n)
  );

  pdc_port_edge #(.WIDTH(PORT_W), .STAGES(SYNC_LEN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pins_i (porta_i),
    .arm_i  (mode == MODE_HALT),
    .fall_o (port_fall)
  );

  pdc_core u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ext_rst_i   (ext_rst_i),
    .halt_cmd_i  (halt_cmd_i),
    .wdt_clr_i   (wdt_clr_i),
    .irq_pend_i  (irq_pend_i),
    .port_fall_i (port_fall),
    .wdt_ovf_i   (wdt_ovf_i),
    .mode_o      (mode),
    .flags_o     (flags),
    .req_o       (req)
  );

  assign halted_o     = (mode == MODE_HALT);
  assign sys_osc_en_o = (mode == MODE_RUN);
  assign pd_flag_o    = flags.pd;
  assign to_flag_o    = flags.to;
  assign full_rst_o   = req.full;
  assign warm_rst_o   = req.warm;
endmodule

// File: rtl/pdc_ctrl_chk.sv
module pdc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_rst_i,
  input logic halt_cmd_i,
  input logic halted_o,
  input logic pd_flag_o,
  input logic to_flag_o,
  input logic full_rst_o,
  input logic warm_rst_o
);
  p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> ($past(halt_cmd_i) && !$past(ext_rst_i)));

  p_halt_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_o) |-> (pd_flag_o && !to_flag_o));

  p_warm_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |-> (to_flag_o && pd_flag_o && !halted_o));

  p_ext_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> (full_rst_o && !pd_flag_o && !to_flag_o && !halted_o));

  p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !ext_rst_i) |=> $stable(pd_flag_o));

  p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_rst_o && warm_rst_o));

  p_warm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_o |=> !warm_rst_o);
endmodule

bind pdc_ctrl pdc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ext_rst_i  (ext_rst_i),
  .halt_cmd_i (halt_cmd_i),
  .halted_o   (halted_o),
  .pd_flag_o  (pd_flag_o),
  .to_flag_o  (to_flag_o),
  .full_rst_o (full_rst_o),
  .warm_rst_o (warm_rst_o)
);

// File: tb/pdc_ctrl_bench.sv
module pdc_ctrl_bench;
  logic       clk = 1'b0;
  logic       por_n;
  logic       ext_rst, halt_cmd, wdt_clr, irq_pend, wdt_ovf;
  logic [7:0] porta;
  logic       osc_en, halted, pd_flag, to_flag, full_rst, warm_rst;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // reference model state
  logic       m_halt, m_pd, m_to, m_full, m_warm;
  logic [7:0] m_s1, m_s2, m_prev;

  always #2 clk = ~clk;

  pdc_ctrl u_pdc_ctrl (
    .clk          (clk),
    .por_n_i      (por_n),
    .ext_rst_i    (ext_rst),
    .halt_cmd_i   (halt_cmd),
    .wdt_clr_i    (wdt_clr),
    .irq_pend_i   (irq_pend),
    .porta_i      (porta),
    .wdt_ovf_i    (wdt_ovf),
    .sys_osc_en_o (osc_en),
    .halted_o     (halted),
    .pd_flag_o    (pd_flag),
    .to_flag_o    (to_flag),
    .full_rst_o   (full_rst),
    .warm_rst_o   (warm_rst)
  );

  function automatic logic [5:0] expect_vec();
    return {~m_halt, m_halt, m_pd, m_to, m_full, m_warm};
  endfunction

  function automatic string pick_tag(logic e, logic o, logic h, logic c, logic was_halt);
    if (e)             return "R6";
    if (o && was_halt) return "R5";
    if (o)             return "R4 R10";
    if (was_halt)      return "R7 R8 R9";
    if (h && c)        return "R11";
    if (h)             return "R2";
    if (c)             return "R3";
    return "R1";
  endfunction

  task automatic model_edge();
    logic fall;
    fall   = m_halt && ((m_prev & ~m_s2) != 8'h00);
    m_full = 1'b0;
    m_warm = 1'b0;
    if (ext_rst) begin
      m_halt = 1'b0; m_pd = 1'b0; m_to = 1'b0; m_full = 1'b1;
    end else if (wdt_ovf) begin
      m_to = 1'b1;
      if (m_halt) begin m_halt = 1'b0; m_warm = 1'b1; end
      else m_full = 1'b1;
    end else if (m_halt) begin
      if (irq_pend || fall) m_halt = 1'b0;
    end else if (halt_cmd) begin
      m_halt = 1'b1; m_pd = 1'b1; m_to = 1'b0;
    end else if (wdt_clr) begin
      m_pd = 1'b0;
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = porta;
  endtask

  task automatic compare(string tag);
    logic [5:0] act, exp_v;
    act   = {osc_en, halted, pd_flag, to_flag, full_rst, warm_rst};
    exp_v = expect_vec();
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s t=%0t {osc,halt,pd,to,full,warm} act=%b exp=%b", tag, $time, act, exp_v);
    end
  endtask

  // called at a negedge: drive, clock, compare at next negedge
  task automatic step(logic e, logic o, logic h, logic c, logic i, logic [7:0] p);
    string tag;
    tag = pick_tag(e, o, h, c, m_halt);
    ext_rst = e; wdt_ovf = o; halt_cmd = h; wdt_clr = c; irq_pend = i; porta = p;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, porta);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1428));
    por_n = 1'b0; ext_rst = 0; halt_cmd = 0; wdt_clr = 0; irq_pend = 0; wdt_ovf = 0;
    porta = 8'hFF;
    m_halt = 0; m_pd = 0; m_to = 0; m_full = 0; m_warm = 0;
    m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF;
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2 halt entry, then R9 commands ignored while halted
    step(0, 0, 1, 0, 0, 8'hFF);
    step(0, 0, 1, 1, 0, 8'hFF);
    step(0, 0, 0, 1, 0, 8'hFF);
    // R7 interrupt wake
    step(0, 0, 0, 0, 1, 8'hFF);
    // R3 clear-watchdog while running
    step(0, 0, 0, 1, 0, 8'hFF);
    // R8 port low before halt does not wake; rising edge while halted does not wake
    step(0, 0, 0, 0, 0, 8'hFE);
    idle(3);
    step(0, 0, 1, 0, 0, 8'hFE);
    step(0, 0, 0, 0, 0, 8'hFF);
    idle(4);
    // R8 falling edge wakes on third edge
    step(0, 0, 0, 0, 0, 8'hF7);
    idle(3);
    // R4 overflow while running, R5 overflow while halted
    step(0, 1, 0, 0, 0, 8'hFF);
    step(0, 0, 1, 0, 0, 8'hFF);
    step(0, 1, 0, 0, 0, 8'hFF);
    idle(1);
    // R11 halt and clear together, then R6 external reset with overflow
    step(0, 0, 1, 1, 0, 8'hFF);
    step(1, 1, 0, 0, 0, 8'hFF);
    step(1, 0, 1, 0, 0, 8'hFF);
    idle(2);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] p;
      p = porta;
      if ($urandom_range(0, 9) == 0) p = p ^ (8'h01 << $urandom_range(0, 7));
      step($urandom_range(0, 99) < 2, $urandom_range(0, 99) < 4,
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 8,
           $urandom_range(0, 99) < 3, p);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule